// File: doc/BRIEF.md
# Two-Bank Register File with Status-Selected Bank

This block is the data memory of a small processor core. The core presents a 7-bit offset on a read port and on a write port. One bit of an internal status register chooses which of two banks that offset falls in. The block then decodes each access into one of three regions: the special-register window at the bottom of the bank, general-purpose RAM, or an unimplemented hole.

The status register lives inside the block and appears at the same offset in both banks. Software can therefore always reach it, whichever bank is selected. One scratch special register has a separate copy in each bank, so the bank-1 copy exists only in bank 1. Reads are combinational. Writes land on the rising clock edge, and a change of bank affects accesses from the following cycle onward.

Top module: `bank_regfile`

## Requirements
- R1: While reset is asserted and right after it, the status register reads 00h and `bank_o` is 0, so bank 0 is selected.
- R2: The bank bit is bit 5 of the status register. The status register sits at offset 03h in both banks. A write there from either bank updates all eight bits, and `bank_o` shows bit 5.
- R3: A status write changes `bank_o` and the bank used for decoding at the next clock edge. `bank_o` changes only when the status register is written.
- R4: In bank 0, offsets 20h to 7Fh are general-purpose RAM that returns the last byte written to it.
- R5: In bank 1, offsets 20h to 3Fh are general-purpose RAM. This storage is separate from bank 0 at the same offsets.
- R6: In bank 1, offsets 40h to 7Fh read 00h. Writes there change no storage, including bank 0 at the same offsets.
- R7: Offsets 00h to 1Fh other than 03h and 06h read 00h in both banks. Writes to them are ignored.
- R8: Offset 06h holds a scratch register with one copy per bank. Each copy returns only what was written to it while its own bank was selected.
- R9: `rd_data` follows `rd_addr` and the current bank in the same cycle. A read of a location being written in that cycle returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, clears the special registers |
| rd_addr | input | 7 | Offset read within the current bank |
| rd_data | output | 8 | Combinational read result, 00h for unimplemented locations |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_addr | input | 7 | Offset written within the current bank |
| wr_data | input | 8 | Byte written at the clock edge |
| bank_o | output | 1 | Currently selected bank (status bit 5) |

## Verification
The assertions check the bank bit on every cycle: its reset value, its update one edge after a status write, and that it holds steady otherwise. They also check on every cycle that the special-register holes and the bank-1 upper hole read zero, and that a status read agrees with `bank_o`. Other behaviour needs history that only the bench's reference model keeps. This covers separate storage behind the same offset in the two banks, writes into holes leaving bank 0 untouched, the per-bank scratch copies, and old-data-on-collision reads. The directed sweeps and the pseudo-random phase exercise these behaviours.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_SFR  = 2'd1,
      RGN_GPR  = 2'd2
   } rgn_e;

   typedef enum logic [1:0] {
      SFR_NONE   = 2'd0,
      SFR_STATUS = 2'd1,
      SFR_AUX    = 2'd2
   } sfr_e;

   typedef struct packed {
      rgn_e rgn;
      sfr_e sfr;
   } acc_t;

endpackage

// File: rtl/dm_decode.sv
module dm_decode
   import bank_rf_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int SFR_CNT    = 32,
   parameter int GP0_TOP    = 127,
   parameter int GP1_TOP    = 63,
   parameter int STATUS_OFF = 3,
   parameter int AUX_OFF    = 6,
   parameter int GIDX_W     = 7
) (
   input  logic              bank,
   input  logic [ADDR_W-1:0] off,
   output acc_t              acc,
   output logic [GIDX_W-1:0] gidx
);
   localparam int                ADDR_MAX = (1 << ADDR_W) - 1;
   localparam int                GP0_SIZE = GP0_TOP - SFR_CNT + 1;
   localparam logic [ADDR_W-1:0] GP_BASE  = ADDR_W'(SFR_CNT);
   localparam logic [ADDR_W-1:0] STA_A    = ADDR_W'(STATUS_OFF);
   localparam logic [ADDR_W-1:0] AUX_A    = ADDR_W'(AUX_OFF);

   logic in_gp0;
   logic in_gp1;
   logic [GIDX_W-1:0] rel;

   // A bank whose RAM reaches the last offset needs no upper compare
   if (GP0_TOP == ADDR_MAX) begin : g_gp0_full
      assign in_gp0 = 1'b1;
   end else begin : g_gp0_part
      assign in_gp0 = (off <= ADDR_W'(GP0_TOP));
   end

   if (GP1_TOP == ADDR_MAX) begin : g_gp1_full
      assign in_gp1 = 1'b1;
   end else begin : g_gp1_part
      assign in_gp1 = (off <= ADDR_W'(GP1_TOP));
   end

   assign rel = GIDX_W'(off - GP_BASE);

   always_comb begin
      acc  = '{rgn: RGN_NONE, sfr: SFR_NONE};
      gidx = '0;
      if (off < GP_BASE) begin
         acc.rgn = RGN_SFR;
         if (off == STA_A)      acc.sfr = SFR_STATUS;
         else if (off == AUX_A) acc.sfr = SFR_AUX;
      end else if (!bank && in_gp0) begin
         acc.rgn = RGN_GPR;
         gidx    = rel;
      end else if (bank && in_gp1) begin
         acc.rgn = RGN_GPR;
         gidx    = rel + GIDX_W'(GP0_SIZE);
      end
   end
endmodule

// File: rtl/dm_sfr.sv
module dm_sfr
   import bank_rf_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int BANK_BIT = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  sfr_e              wsel,
   input  logic [DATA_W-1:0] wdata,
   input  sfr_e              rsel,
   output logic [DATA_W-1:0] rdata,
   output logic              bank
);
   localparam int NBANK = 2;

   logic [DATA_W-1:0] status_q;
   logic [DATA_W-1:0] aux_rd [NBANK];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          status_q <= '0;
      else if (we && wsel == SFR_STATUS)   status_q <= wdata;
   end

   assign bank = status_q[BANK_BIT];

   for (genvar b = 0; b < NBANK; b++) begin : g_aux
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                       q <= '0;
         else if (we && wsel == SFR_AUX && bank == b[0])   q <= wdata;
      end
      assign aux_rd[b] = q;
   end

   always_comb begin
      unique case (rsel)
         SFR_STATUS: rdata = status_q;
         SFR_AUX:    rdata = aux_rd[bank];
         default:    rdata = '0;
      endcase
   end
endmodule

// File: rtl/dm_gpr.sv
module dm_gpr #(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 128,
   parameter int GIDX_W    = 7,
   parameter bit RAM_RESET = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [GIDX_W-1:0] widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [GIDX_W-1:0] ridx,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   if (RAM_RESET) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (we) begin
            mem[widx] <= wdata;
         end
      end
   end else begin : g_plain
      logic unused_rst;
      assign unused_rst = rst_n;
      always_ff @(posedge clk) begin
         if (we) mem[widx] <= wdata;
      end
   end

   assign rdata = mem[ridx];
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
   import bank_rf_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int DATA_W     = 8,
   parameter int BANK_BIT   = 5,
   parameter int SFR_CNT    = 32,
   parameter int GP0_TOP    = 127,
   parameter int GP1_TOP    = 63,
   parameter int STATUS_OFF = 3,
   parameter int AUX_OFF    = 6,
   parameter bit RAM_RESET  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              bank_o
);
   localparam int GP0_SIZE = GP0_TOP - SFR_CNT + 1;
   localparam int GP1_SIZE = GP1_TOP - SFR_CNT + 1;
   localparam int GP_TOTAL = GP0_SIZE + GP1_SIZE;
   localparam int GIDX_W   = $clog2(GP_TOTAL);

   // Elaboration-time parameter checks
   if (BANK_BIT >= DATA_W) begin : g_bad_bank
      $error("bank bit outside status width");
   end
   if (GP0_TOP >= (1 << ADDR_W) || GP1_TOP >= (1 << ADDR_W)) begin : g_bad_top
      $error("RAM top beyond address span");
   end
   if (GP0_SIZE < 1 || GP1_SIZE < 1) begin : g_bad_size
      $error("each bank needs RAM above the special window");
   end
   if (STATUS_OFF >= SFR_CNT || AUX_OFF >= SFR_CNT || STATUS_OFF == AUX_OFF) begin : g_bad_sfr
      $error("special register offsets invalid");
   end

   acc_t              racc, wacc;
   logic [GIDX_W-1:0] ridx, widx;
   logic [DATA_W-1:0] sfr_rd, gpr_rd;
   logic              bank;

   dm_decode #(
      .ADDR_W(ADDR_W), .SFR_CNT(SFR_CNT), .GP0_TOP(GP0_TOP), .GP1_TOP(GP1_TOP),
      .STATUS_OFF(STATUS_OFF), .AUX_OFF(AUX_OFF), .GIDX_W(GIDX_W)
   ) u_rdec (.bank(bank), .off(rd_addr), .acc(racc), .gidx(ridx));

   dm_decode #(
      .ADDR_W(ADDR_W), .SFR_CNT(SFR_CNT), .GP0_TOP(GP0_TOP), .GP1_TOP(GP1_TOP),
      .STATUS_OFF(STATUS_OFF), .AUX_OFF(AUX_OFF), .GIDX_W(GIDX_W)
   ) u_wdec (.bank(bank), .off(wr_addr), .acc(wacc), .gidx(widx));

   dm_sfr #(.DATA_W(DATA_W), .BANK_BIT(BANK_BIT)) u_sfr (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && wacc.rgn == RGN_SFR), .wsel(wacc.sfr), .wdata(wr_data),
      .rsel(racc.sfr), .rdata(sfr_rd), .bank(bank)
   );

   dm_gpr #(.DATA_W(DATA_W), .DEPTH(GP_TOTAL), .GIDX_W(GIDX_W), .RAM_RESET(RAM_RESET)) u_gpr (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && wacc.rgn == RGN_GPR), .widx(widx), .wdata(wr_data),
      .ridx(ridx), .rdata(gpr_rd)
   );

   always_comb begin
      unique case (racc.rgn)
         RGN_SFR: rd_data = sfr_rd;
         RGN_GPR: rd_data = gpr_rd;
         default: rd_data = '0;
      endcase
   end

   assign bank_o = bank;
endmodule

// File: rtl/bank_regfile_chk.sv
module bank_regfile_chk #(
   parameter int ADDR_W     = 7,
   parameter int DATA_W     = 8,
   parameter int BANK_BIT   = 5,
   parameter int SFR_CNT    = 32,
   parameter int GP1_TOP    = 63,
   parameter int STATUS_OFF = 3,
   parameter int AUX_OFF    = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              bank_o
);
   localparam logic [ADDR_W-1:0] STA_A   = ADDR_W'(STATUS_OFF);
   localparam logic [ADDR_W-1:0] AUX_A   = ADDR_W'(AUX_OFF);
   localparam logic [ADDR_W-1:0] GP_BASE = ADDR_W'(SFR_CNT);
   localparam logic [ADDR_W-1:0] GP1_END = ADDR_W'(GP1_TOP);

   logic sta_wr;
   assign sta_wr = wr_en && (wr_addr == STA_A);

   assert_reset_bank_R1: assert property (@(posedge clk)
      !rst_n |=> !bank_o);

   assert_status_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sta_wr |=> (bank_o == $past(wr_data[BANK_BIT])));

   assert_status_view_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == STA_A) |-> (rd_data[BANK_BIT] == bank_o));

   assert_bank_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !sta_wr |=> $stable(bank_o));

   assert_upper_hole_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_o && rd_addr > GP1_END) |-> (rd_data == '0));

   assert_sfr_hole_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr < GP_BASE && rd_addr != STA_A && rd_addr != AUX_A) |-> (rd_data == '0));
endmodule

bind bank_regfile bank_regfile_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_BIT(BANK_BIT), .SFR_CNT(SFR_CNT),
   .GP1_TOP(GP1_TOP), .STATUS_OFF(STATUS_OFF), .AUX_OFF(AUX_OFF)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .bank_o(bank_o)
);

// File: tb/sim_bank_regfile.sv
`timescale 1ns/1ps
module sim_bank_regfile;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] rd_addr = 7'h03;
   logic [7:0] rd_data;
   logic       wr_en = 1'b0;
   logic [6:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       bank_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Behavioural reference state
   logic [7:0] m0 [128];
   logic [7:0] m1 [128];
   logic [7:0] st = 8'h00;
   logic [7:0] ax0 = 8'h00;
   logic [7:0] ax1 = 8'h00;

   always #10 clk = ~clk;   // 50 MHz

   bank_regfile u0 (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .bank_o(bank_o)
   );

   function automatic logic [7:0] ref_rd(input logic [6:0] a);
      logic b = st[5];
      if (a == 7'h03)      return st;
      if (a == 7'h06)      return b ? ax1 : ax0;
      if (a < 7'h20)       return 8'h00;
      if (!b)              return m0[a];
      if (a < 7'h40)       return m1[a];
      return 8'h00;
   endfunction

   function automatic string tag_of(input logic [6:0] a);
      if (a == 7'h03)           return "R2";
      if (a == 7'h06)           return "R8";
      if (a < 7'h20)            return "R7";
      if (st[5] && a >= 7'h40)  return "R6";
      if (st[5])                return "R5";
      return "R4";
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h (t=%0t)", req, act, exp, $time);
      end
   endtask

   // One clock: drive, compare away from the edge, advance the model
   task automatic cyc(input logic we, input logic [6:0] wa, input logic [7:0] wd,
                      input logic [6:0] ra, input string tag);
      logic b;
      wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
      #2;
      check((tag == "") ? tag_of(ra) : tag, rd_data, ref_rd(ra));
      check("R3", {7'd0, bank_o}, {7'd0, st[5]});
      b = st[5];
      if (we) begin
         if (wa == 7'h03)      st = wd;
         else if (wa == 7'h06) begin if (b) ax1 = wd; else ax0 = wd; end
         else if (wa >= 7'h20) begin
            if (!b)            m0[wa] = wd;
            else if (wa < 7'h40) m1[wa] = wd;
         end
      end
      @(negedge clk);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf = 16'hACE1;
      @(negedge clk);
      #2;
      // R1: reset state
      check("R1", rd_data, 8'h00);
      check("R1", {7'd0, bank_o}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {7'd0, bank_o}, 8'h00);

      // Fill bank 0 RAM (R4)
      for (int a = 32; a < 128; a++) cyc(1'b1, 7'(a), 8'(a) ^ 8'hA5, 7'h03, "");
      // Select bank 1 through status bit 5 (R2), fill including the hole (R5, R6)
      cyc(1'b1, 7'h03, 8'h20, 7'h03, "R2");
      for (int a = 32; a < 128; a++) cyc(1'b1, 7'(a), 8'(a) ^ 8'h3C, 7'h03, "");
      // Back to bank 0 via the bank-1 view of the status register (R2)
      cyc(1'b1, 7'h03, 8'h00, 7'h03, "R2");
      // Read everything in bank 0: R6 hole writes must not show here
      for (int a = 0; a < 128; a++) cyc(1'b0, 7'h00, 8'h00, 7'(a), "");
      cyc(1'b1, 7'h03, 8'hFF, 7'h03, "R2");
      for (int a = 0; a < 128; a++) cyc(1'b0, 7'h00, 8'h00, 7'(a), "");

      // R8: per-bank scratch copies
      cyc(1'b1, 7'h06, 8'h5A, 7'h06, "R8");
      cyc(1'b1, 7'h03, 8'h00, 7'h06, "R8");
      cyc(1'b1, 7'h06, 8'hC3, 7'h06, "R8");
      cyc(1'b0, 7'h00, 8'h00, 7'h06, "R8");
      // R7: write to a special hole, read back zero
      cyc(1'b1, 7'h11, 8'h77, 7'h11, "R7");
      cyc(1'b0, 7'h00, 8'h00, 7'h11, "R7");
      // R9: same-cycle collision returns old data, then new
      cyc(1'b1, 7'h30, 8'h99, 7'h30, "R9");
      cyc(1'b0, 7'h00, 8'h00, 7'h30, "R9");
      // R3: bank switch during a read of 25h; next cycle sees bank 1
      cyc(1'b1, 7'h03, 8'h20, 7'h25, "R3");
      cyc(1'b0, 7'h00, 8'h00, 7'h25, "R3");
      cyc(1'b1, 7'h50, 8'hEE, 7'h50, "R6");
      cyc(1'b1, 7'h03, 8'h00, 7'h50, "R6");
      cyc(1'b0, 7'h00, 8'h00, 7'h50, "R6");

      // Pseudo-random traffic
      for (int i = 0; i < 2000; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         cyc(lf[0], (lf[4:1] == 4'h0) ? 7'h03 : lf[7:1], lf[15:8], lf[14:8], "");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule